// File: doc/BRIEF.md
# Endpoint Packet Buffer Data Port

This block holds one packet in each direction for a single endpoint. A microcontroller reaches both buffers through one data-port address. It uses a second address to issue one-shot control commands. Each data-port access moves one byte on a narrow access or two bytes on a wide access. The byte at the lower buffer position always travels in bits 7:0.

On the transmit side, software fills the buffer and the packet becomes ready by itself once the buffer holds a full packet. Software can also force a shorter packet out. A ready packet is streamed out one byte per cycle on each IN token. It stays ready, and can be sent again, until the host acknowledges it.

On the receive side, an OUT token opens the empty buffer to a byte stream. The end-of-packet strobe closes it. Software drains the packet through the data port, and the buffer frees itself when the last byte is read. Software can also empty it by command. The USB side is reduced to token, acknowledge and byte-stream strobes.

Top module: `ep_data_port`

## Requirements
- R1: The data port sits at address 0x20. A narrow write (`cpu_wide`=0) there stores `cpu_wdata[7:0]` as the next transmit byte and raises the transmit count by one.
- R2: A wide write to the data port stores bits 7:0 and then bits 15:8 as two consecutive bytes and raises the count by two. When only one free slot remains, only bits 7:0 are stored and the count rises by one.
- R3: When the transmit count reaches MAX_PKT, `tx_pending` rises without software action. In the cycle after an IN token with a packet pending, the bytes appear in buffer order, one per cycle, on `tx_valid`/`tx_data`. `tx_end` marks the final byte.
- R4: The control register sits at address 0x28. Writing a 1 to bit 3 makes a partly filled or empty transmit buffer pending. An empty packet is sent as a lone `tx_end` with `tx_valid` low.
- R5: While a packet is pending, data-port writes are ignored. A second IN token before the acknowledge resends the same bytes. `in_ack` clears the pending flag and empties the transmit buffer.
- R6: An IN token with no packet pending raises `in_nak` in the same cycle and starts no transfer.
- R7: An OUT token with the receive buffer empty opens it. Each `rx_valid` byte is stored, and bytes beyond MAX_PKT are dropped. `rx_end` raises `rx_full` with `rx_count` equal to the number of stored bytes. An OUT token while a packet is unread raises `out_nak` in the same cycle.
- R8: A read of the data port returns data in the same cycle. A narrow read returns the next byte in bits 7:0 with bits 15:8 zero, and lowers `rx_count` by one. A wide read returns two bytes, the earlier byte in bits 7:0, and lowers `rx_count` by two.
- R9: A wide read when one byte remains returns that byte in bits 7:0 with bits 15:8 zero, and lowers `rx_count` by one.
- R10: Reading the last byte clears `rx_full`. The next OUT token is then accepted without a NAK.
- R11: Writing a 1 to control bit 4 empties the receive buffer (`rx_full`=0, `rx_count`=0). It leaves the transmit buffer and its count unchanged.
- R12: Control bits 7:5 and 2:0 have no effect when written. Bits 3 and 4 act only at the moment of the write. A read of the control register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 8 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid while `cpu_rd` is high |
| in_token | input | 1 | IN token strobe |
| in_ack | input | 1 | Host acknowledged the IN packet |
| in_nak | output | 1 | IN token refused, nothing pending |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_end | output | 1 | Last cycle of a transmit packet |
| tx_pending | output | 1 | Transmit packet ready |
| out_token | input | 1 | OUT token strobe |
| out_nak | output | 1 | OUT token refused, buffer occupied |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of received packet |
| rx_full | output | 1 | Unread received packet present |
| rx_count | output | $clog2(MAX_PKT+1) | Received bytes still unread |

## Verification
The bench builds the block with MAX_PKT = 7. An odd packet size lets a run of wide writes end with one free slot, which exercises the half-stored write. It also leaves an odd byte count on receive, so a wide read meets the single remaining byte. The small size keeps automatic validation and receive overflow (nine bytes offered) within a few cycles of directed stimulus.

// File: rtl/ep_port_pkg.sv
package ep_port_pkg;
  localparam logic [7:0] ADDR_DPORT = 8'h20;
  localparam logic [7:0] ADDR_CTRL  = 8'h28;
  localparam int CTRL_VALIDATE_BIT = 3;
  localparam int CTRL_FLUSH_BIT    = 4;

  typedef struct packed {
    logic dp_wr;
    logic dp_rd;
    logic wide;
    logic force_val;
    logic force_clr;
  } cpu_cmd_t;
endpackage

// File: rtl/ep_port_decode.sv
module ep_port_decode
  import ep_port_pkg::*;
(
  input  logic [7:0]  cpu_addr,
  input  logic        cpu_wr,
  input  logic        cpu_rd,
  input  logic        cpu_wide,
  input  logic [15:0] cpu_wdata,
  input  logic [15:0] rx_rdata,
  output cpu_cmd_t    cmd,
  output logic [15:0] cpu_rdata
);
  logic hit_dport;
  logic hit_ctrl;

  always_comb begin
    hit_dport     = (cpu_addr == ADDR_DPORT);
    hit_ctrl      = (cpu_addr == ADDR_CTRL);
    cmd.dp_wr     = cpu_wr && hit_dport;
    cmd.dp_rd     = cpu_rd && !cpu_wr && hit_dport;
    cmd.wide      = cpu_wide;
    cmd.force_val = cpu_wr && hit_ctrl && cpu_wdata[CTRL_VALIDATE_BIT];
    cmd.force_clr = cpu_wr && hit_ctrl && cpu_wdata[CTRL_FLUSH_BIT];
    // control register has no readable state
    cpu_rdata     = cmd.dp_rd ? rx_rdata : 16'h0000;
  end
endmodule

// File: rtl/ep_tx_buf.sv
module ep_tx_buf #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int IW = $clog2(MAX_PKT)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dp_wr,
  input  logic        wide,
  input  logic [15:0] wdata,
  input  logic        force_val,
  input  logic        in_token,
  input  logic        in_ack,
  output logic        in_nak,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_end,
  output logic        pending
);
  logic [7:0]    mem_q [MAX_PKT];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] sidx_q, sidx_d;
  logic          pend_q, pend_d;
  logic          send_q, send_d;

  logic [CW-1:0] space;
  logic          accept, two, wr_lo, wr_hi, send_last;
  logic [IW-1:0] widx, widx_hi;

  always_comb begin
    space     = CW'(MAX_PKT) - cnt_q;
    accept    = dp_wr && !pend_q;
    two       = wide && (space > CW'(1));
    wr_lo     = accept;
    wr_hi     = accept && two;
    widx      = cnt_q[IW-1:0];
    widx_hi   = widx + IW'(1);
    send_last = send_q && ((sidx_q + CW'(1)) >= cnt_q);
    tx_valid  = send_q && (sidx_q < cnt_q);
    tx_data   = tx_valid ? mem_q[sidx_q[IW-1:0]] : 8'h00;
    tx_end    = send_last;
    in_nak    = in_token && !pend_q;
    pending   = pend_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    send_d = send_q;
    sidx_d = sidx_q;
    if (accept) begin
      cnt_d = cnt_q + (two ? CW'(2) : CW'(1));
      if (cnt_d == CW'(MAX_PKT)) pend_d = 1'b1;
    end
    if (force_val && !pend_q) pend_d = 1'b1;
    if (send_q) begin
      sidx_d = sidx_q + CW'(1);
      if (send_last) send_d = 1'b0;
    end else if (in_token && pend_q) begin
      send_d = 1'b1;
      sidx_d = '0;
    end
    if (in_ack && pend_q && !send_q) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sidx_q <= '0;
      pend_q <= 1'b0;
      send_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sidx_q <= sidx_d;
      pend_q <= pend_d;
      send_q <= send_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_lo) mem_q[widx]    <= wdata[7:0];
    if (wr_hi) mem_q[widx_hi] <= wdata[15:8];
  end

  AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PKT)); // R2
  AST_TX_AUTO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(MAX_PKT)) |-> pend_q); // R3
  AST_TX_STREAM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend_q); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !in_ack) |=> (pend_q && $stable(cnt_q))); // R5
endmodule

// File: rtl/ep_rx_buf.sv
module ep_rx_buf #(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int IW = $clog2(MAX_PKT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_rd,
  input  logic          wide,
  input  logic          force_clr,
  input  logic          out_token,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_end,
  output logic          out_nak,
  output logic [15:0]   rdata,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [7:0]    mem_q [MAX_PKT];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] ridx_q, ridx_d;
  logic          full_q, full_d;
  logic          recv_q, recv_d;

  logic          rd_ok, rtwo, we;
  logic [IW-1:0] ridx_hi;
  logic [CW-1:0] rstep;

  always_comb begin
    rd_ok   = dp_rd && full_q;
    rtwo    = wide && (cnt_q > CW'(1));
    rstep   = rtwo ? CW'(2) : CW'(1);
    ridx_hi = ridx_q + IW'(1);
    rdata[7:0]  = rd_ok ? mem_q[ridx_q] : 8'h00;
    rdata[15:8] = (rd_ok && rtwo) ? mem_q[ridx_hi] : 8'h00;
    we      = recv_q && rx_valid && (cnt_q < CW'(MAX_PKT)) && !force_clr;
    out_nak = out_token && (full_q || recv_q);
    full    = full_q;
    count   = cnt_q;
  end

  always_comb begin
    cnt_d  = cnt_q;
    ridx_d = ridx_q;
    full_d = full_q;
    recv_d = recv_q;
    if (rd_ok) begin
      cnt_d  = cnt_q - rstep;
      ridx_d = ridx_q + rstep[IW-1:0];
      if (cnt_q == rstep) begin
        full_d = 1'b0;
        ridx_d = '0;
      end
    end
    if (out_token && !full_q && !recv_q) begin
      recv_d = 1'b1;
      cnt_d  = '0;
      ridx_d = '0;
    end
    if (we) cnt_d = cnt_q + CW'(1);
    if (recv_q && rx_end) begin
      recv_d = 1'b0;
      full_d = (cnt_d != '0);
    end
    if (force_clr) begin
      full_d = 1'b0;
      recv_d = 1'b0;
      cnt_d  = '0;
      ridx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ridx_q <= '0;
      full_q <= 1'b0;
      recv_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ridx_q <= ridx_d;
      full_q <= full_d;
      recv_q <= recv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem_q[cnt_q[IW-1:0]] <= rx_data;
  end

  AST_RX_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PKT)); // R7
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !dp_rd && !force_clr) |=> (full_q && $stable(cnt_q))); // R7
  AST_RX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && !recv_q) |-> (cnt_q == '0)); // R10
  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && recv_q)); // R7
endmodule

// File: rtl/ep_data_port.sv
module ep_data_port
  import ep_port_pkg::*;
#(
  parameter int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cpu_wide,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  input  logic          in_token,
  input  logic          in_ack,
  output logic          in_nak,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_end,
  output logic          tx_pending,
  input  logic          out_token,
  output logic          out_nak,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_end,
  output logic          rx_full,
  output logic [CW-1:0] rx_count
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  cpu_cmd_t    cmd;
  logic [15:0] rx_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ep_port_decode u_decode (
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wide  (cpu_wide),
    .cpu_wdata (cpu_wdata),
    .rx_rdata  (rx_rdata),
    .cmd       (cmd),
    .cpu_rdata (cpu_rdata)
  );

  ep_tx_buf #(.MAX_PKT(MAX_PKT)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dp_wr     (cmd.dp_wr),
    .wide      (cmd.wide),
    .wdata     (cpu_wdata),
    .force_val (cmd.force_val),
    .in_token  (in_token),
    .in_ack    (in_ack),
    .in_nak    (in_nak),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_end    (tx_end),
    .pending   (tx_pending)
  );

  ep_rx_buf #(.MAX_PKT(MAX_PKT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dp_rd     (cmd.dp_rd),
    .wide      (cmd.wide),
    .force_clr (cmd.force_clr),
    .out_token (out_token),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_end    (rx_end),
    .out_nak   (out_nak),
    .rdata     (rx_rdata),
    .full      (rx_full),
    .count     (rx_count)
  );
endmodule

// File: tb/tb_ep_data_port.sv
module tb_ep_data_port;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 7;
  localparam int CWB = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_wide = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic in_token = 1'b0, in_ack = 1'b0;
  logic in_nak, tx_valid, tx_end, tx_pending;
  logic [7:0] tx_data;
  logic out_token = 1'b0, out_nak;
  logic rx_valid = 1'b0, rx_end = 1'b0, rx_full;
  logic [7:0] rx_data = '0;
  logic [CWB-1:0] rx_count;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_data_port #(.MAX_PKT(MAXP)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [15:0] d, input logic w);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wide = w; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wide = w; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  // Issue an IN token and compare the streamed packet with the expected bytes.
  task automatic tx_expect(input string req, input int n, input logic [63:0] bytes);
    int got = 0;
    bit ended = 1'b0;
    @(negedge clk);
    in_token = 1'b1;
    #1 chk(req, in_nak, 0);
    @(negedge clk);
    in_token = 1'b0;
    for (int c = 0; c < 20 && !ended; c++) begin
      #1;
      if (tx_valid) begin
        chk(req, tx_data, bytes[8*got +: 8]);
        got++;
      end
      if (tx_end) ended = 1'b1;
      @(negedge clk);
    end
    chk(req, got, n);
    chk(req, ended, 1);
  endtask

  task automatic ack_in();
    @(negedge clk);
    in_ack = 1'b1;
    @(negedge clk);
    in_ack = 1'b0;
  endtask

  task automatic out_packet(input int n, input logic [7:0] base, input logic exp_nak, input string req);
    @(negedge clk);
    out_token = 1'b1;
    #1 chk(req, out_nak, exp_nak);
    @(negedge clk);
    out_token = 1'b0;
    if (!exp_nak) begin
      for (int i = 0; i < n; i++) begin
        rx_valid = 1'b1; rx_data = base + 8'(i);
        @(negedge clk);
      end
      rx_valid = 1'b0; rx_end = 1'b1;
      @(negedge clk);
      rx_end = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R6 reset", tx_pending, 0);
    chk("R7 reset", rx_full, 0);
    chk("R7 reset", rx_count, 0);
    @(negedge clk);
    in_token = 1'b1;
    #1 chk("R6", in_nak, 1);
    chk("R6", tx_valid, 0);
    @(negedge clk);
    in_token = 1'b0;
    #1 chk("R6", tx_valid | tx_end, 0);
  endtask

  task automatic t_full_wide();
    cpu_write(8'h20, 16'h2211, 1'b1);
    cpu_write(8'h20, 16'h4433, 1'b1);
    cpu_write(8'h20, 16'h6655, 1'b1);
    chk("R2", tx_pending, 0);
    cpu_write(8'h20, 16'h8877, 1'b1);  // one slot left: only 0x77 stored
    chk("R3", tx_pending, 1);
    cpu_write(8'h20, 16'h0099, 1'b0);  // ignored while pending
    tx_expect("R3", 7, 64'h0077_6655_4433_2211);
    tx_expect("R5", 7, 64'h0077_6655_4433_2211);
    ack_in();
    chk("R5", tx_pending, 0);
    @(negedge clk);
    in_token = 1'b1;
    #1 chk("R6", in_nak, 1);
    @(negedge clk);
    in_token = 1'b0;
  endtask

  task automatic t_short_narrow();
    cpu_write(8'h20, 16'hFFA1, 1'b0);
    cpu_write(8'h20, 16'hEEA2, 1'b0);
    chk("R1", tx_pending, 0);
    cpu_write(8'h28, 16'h0008, 1'b0);
    chk("R4", tx_pending, 1);
    tx_expect("R1", 2, 64'h0000_0000_0000_A2A1);
    ack_in();
    cpu_write(8'h28, 16'h0008, 1'b0);
    chk("R4", tx_pending, 1);
    tx_expect("R4", 0, 64'h0);
    ack_in();
    chk("R4", tx_pending, 0);
  endtask

  task automatic t_rx_drain();
    logic [15:0] d;
    out_packet(5, 8'h10, 1'b0, "R7");
    chk("R7", rx_full, 1);
    chk("R7", rx_count, 5);
    out_packet(0, 8'h00, 1'b1, "R7");
    chk("R7", rx_count, 5);
    cpu_read(8'h20, 1'b1, d);
    chk("R8", d, 16'h1110);
    chk("R8", rx_count, 3);
    cpu_read(8'h20, 1'b0, d);
    chk("R8", d, 16'h0012);
    chk("R8", rx_count, 2);
    cpu_read(8'h20, 1'b1, d);
    chk("R8", d, 16'h1413);
    chk("R10", rx_full, 0);
    chk("R10", rx_count, 0);
    out_packet(3, 8'h20, 1'b0, "R10");
    chk("R10", rx_full, 1);
  endtask

  task automatic t_rx_odd();
    logic [15:0] d;
    cpu_read(8'h20, 1'b1, d);
    chk("R9", d, 16'h2120);
    cpu_read(8'h20, 1'b1, d);
    chk("R9", d, 16'h0022);
    chk("R9", rx_count, 0);
    chk("R10", rx_full, 0);
    out_packet(9, 8'h40, 1'b0, "R7");
    chk("R7 overflow", rx_count, 7);
    for (int i = 0; i < 7; i++) cpu_read(8'h20, 1'b0, d);
    chk("R7 overflow", d, 16'h0046);
    chk("R10", rx_full, 0);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    cpu_write(8'h20, 16'h0055, 1'b0);
    out_packet(4, 8'h30, 1'b0, "R11");
    cpu_write(8'h28, 16'h00E7, 1'b0);
    chk("R12", rx_full, 1);
    chk("R12", rx_count, 4);
    chk("R12", tx_pending, 0);
    cpu_read(8'h28, 1'b1, d);
    chk("R12", d, 16'h0000);
    cpu_write(8'h28, 16'h0010, 1'b0);
    chk("R11", rx_full, 0);
    chk("R11", rx_count, 0);
    chk("R11", tx_pending, 0);
    cpu_write(8'h28, 16'h0008, 1'b0);
    tx_expect("R11", 1, 64'h55);
    ack_in();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_full_wide();
    t_short_narrow();
    t_rx_drain();
    t_rx_odd();
    t_ctrl();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule